// File: doc/BRIEF.md
# Parking Occupancy Ones Counter

This block counts how many spaces of a forty-space car park are taken. Every space has a sensor that drives one input bit, high when a vehicle is present and low when the space is free. The block adds up the high bits wherever they sit in the vector. It presents the total as two binary-coded decimal digits, ready for a two-digit decimal display. A separate flag goes high when every space is taken.

The logic is purely combinational, with no clock and no reset. The structure is hierarchical. A small counting cell handles four sensors and reports a three-bit count from 0 to 4. Ten such cells feed an adder chain that forms a six-bit binary total from 0 to 40. A converter then splits that total into a tens digit and a units digit. The interface has no data stream, so there is no valid/ready handshake and no back-pressure. The input vector is sampled continuously and the outputs follow it after propagation delay.

Top module: `occ_counter`

## Requirements
- R1: The decimal value tens_o*10 + units_o equals the number of 1 bits in slot_occ_i, for every input pattern.
- R2: The result depends only on how many bits are set, not on which bit positions hold them; the same count placed in the low bits, the high bits or scattered gives identical outputs.
- R3: Both digits are BCD: units_o always lies in 0 to 9 and tens_o in 0 to 4.
- R4: full_o is 1 exactly when all 40 bits of slot_occ_i are 1, and the digits then read tens 4, units 0.
- R5: With 39 spaces taken, whichever one is free, full_o is 0 and the digits read tens 3, units 9.
- R6: With no space taken, tens_o and units_o are both 0 and full_o is 0.
- R7: Four taken spaces that all belong to one group of four adjacent inputs (bits 4k to 4k+3, for any k from 0 to 9) read as units 4, tens 0.
- R8: A count that crosses a decimal boundary (9 to 10, 19 to 20, 29 to 30, 39 to 40) carries into the tens digit, and the units digit returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slot_occ_i | input | 40 | One bit per parking space; 1 means taken |
| tens_o | output | 4 | BCD tens digit of the taken-space count (0 to 4) |
| units_o | output | 4 | BCD units digit of the taken-space count (0 to 9) |
| full_o | output | 1 | High only when all 40 spaces are taken |

## Verification
Random vectors almost never produce the extreme totals, because each of the 40 bits is set independently and the count clusters near 20. So the full flag, the 39-space case and the decimal carries are rarely reached from the ports by chance. The stimulus therefore walks every density from 0 to 40 twice, once filling from bit 0 upward and once from bit 39 downward. It then clears each single bit of the all-taken vector in turn and fills each four-bit group alone, before a random phase covers scattered placements.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int SLOTS_DEF = 40;
  localparam int CELL_DEF  = 4;
  localparam int DIGIT_W   = 4;

  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/occ_cell.sv
module occ_cell #(
  parameter int W    = occ_pkg::CELL_DEF,
  parameter int CW   = occ_pkg::cnt_width(W)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] ones_o
);
  always_comb begin
    ones_o = '0;
    for (int b = 0; b < W; b++)
      ones_o = ones_o + CW'(bits_i[b]);
  end
endmodule

// File: rtl/occ_sum.sv
module occ_sum #(
  parameter int SLOTS = occ_pkg::SLOTS_DEF,
  parameter int CELL  = occ_pkg::CELL_DEF,
  parameter int TOT_W = occ_pkg::cnt_width(SLOTS)
) (
  input  logic [SLOTS-1:0] vec_i,
  output logic [TOT_W-1:0] total_o
);
  localparam int NCELLS = (SLOTS + CELL - 1) / CELL;
  localparam int PAD_W  = NCELLS * CELL;
  localparam int CELL_CW = occ_pkg::cnt_width(CELL);

  logic [PAD_W-1:0]   padded;
  logic [CELL_CW-1:0] cell_cnt [NCELLS];
  logic [TOT_W-1:0]   chain    [NCELLS+1];

  generate
    if (PAD_W > SLOTS) begin : g_pad
      assign padded = {{(PAD_W-SLOTS){1'b0}}, vec_i};
    end else begin : g_nopad
      assign padded = vec_i;
    end
  endgenerate

  assign chain[0] = '0;

  for (genvar g = 0; g < NCELLS; g++) begin : g_cell
    occ_cell #(.W(CELL), .CW(CELL_CW)) cell_i (
      .bits_i (padded[g*CELL +: CELL]),
      .ones_o (cell_cnt[g])
    );
    assign chain[g+1] = chain[g] + TOT_W'(cell_cnt[g]);
  end

  assign total_o = chain[NCELLS];
endmodule

// File: rtl/occ_bcd.sv
module occ_bcd #(
  parameter int MAXV  = occ_pkg::SLOTS_DEF,
  parameter int IN_W  = occ_pkg::cnt_width(MAXV),
  parameter int DW    = occ_pkg::DIGIT_W
) (
  input  logic [IN_W-1:0] bin_i,
  output logic [DW-1:0]   tens_o,
  output logic [DW-1:0]   units_o
);
  localparam int TENS_MAX = MAXV / 10;

  always_comb begin
    int v;
    v      = int'(bin_i);
    tens_o = '0;
    for (int k = 1; k <= TENS_MAX; k++)
      if (v >= k * 10) tens_o = DW'(k);
    units_o = DW'(v - int'(tens_o) * 10);
  end
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int SLOTS = occ_pkg::SLOTS_DEF,
  parameter int CELL  = occ_pkg::CELL_DEF
) (
  input  logic [SLOTS-1:0] slot_occ_i,
  output logic [3:0]       tens_o,
  output logic [3:0]       units_o,
  output logic             full_o
);
  localparam int TOT_W = occ_pkg::cnt_width(SLOTS);

  logic [TOT_W-1:0] total;

  occ_sum #(.SLOTS(SLOTS), .CELL(CELL), .TOT_W(TOT_W)) sum_i (
    .vec_i   (slot_occ_i),
    .total_o (total)
  );

  occ_bcd #(.MAXV(SLOTS), .IN_W(TOT_W), .DW(4)) bcd_i (
    .bin_i   (total),
    .tens_o  (tens_o),
    .units_o (units_o)
  );

  assign full_o = (total == TOT_W'(SLOTS));
endmodule

// File: rtl/occ_counter_chk.sv
module occ_counter_chk #(
  parameter int SLOTS = occ_pkg::SLOTS_DEF
) (
  input logic [SLOTS-1:0] slot_occ_i,
  input logic [3:0]       tens_o,
  input logic [3:0]       units_o,
  input logic             full_o
);
  always_comb begin
    assert_digits_bcd_R3: assert (units_o <= 4'd9 && tens_o <= 4'd4)
      else $error("units or tens digit out of range");
    assert_value_popcount_R1: assert (int'(tens_o) * 10 + int'(units_o) == $countones(slot_occ_i))
      else $error("decimal value differs from number of set inputs");
    assert_full_all_R4: assert (full_o == (&slot_occ_i))
      else $error("full flag disagrees with all-taken input");
    assert_empty_zero_R6: assert (!(slot_occ_i == '0) || (tens_o == 4'd0 && units_o == 4'd0 && !full_o))
      else $error("empty input gives nonzero result");
    assert_full_digits_R4: assert (!full_o || (tens_o == 4'd4 && units_o == 4'd0))
      else $error("full flag with wrong digits");
  end
endmodule

bind occ_counter occ_counter_chk #(.SLOTS(SLOTS)) chk_i (
  .slot_occ_i (slot_occ_i),
  .tens_o     (tens_o),
  .units_o    (units_o),
  .full_o     (full_o)
);

// File: tb/occ_counter_test.sv
module occ_counter_test;
  localparam int N = 40;

  logic         clk = 1'b0;
  logic [N-1:0] occ = '0;
  logic [3:0]   tens, units;
  logic         full;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  occ_counter uut (
    .slot_occ_i (occ),
    .tens_o     (tens),
    .units_o    (units),
    .full_o     (full)
  );

  function automatic int ref_count(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic apply(input logic [N-1:0] v, input string req);
    int c, et, eu;
    bit ef;
    @(posedge clk);
    occ = v;
    @(negedge clk);
    c  = ref_count(v);
    et = c / 10;
    eu = c % 10;
    ef = (c == N);
    n_run++;
    if (int'(tens) != et || int'(units) != eu || full != ef) begin
      n_fail++;
      $display("FAIL %s: in=%h got tens=%0d units=%0d full=%0b exp tens=%0d units=%0d full=%0b",
               req, v, tens, units, full, et, eu, ef);
    end
  endtask

  function automatic logic [N-1:0] low_ones(input int k);
    logic [N-1:0] m = '0;
    for (int i = 0; i < k; i++) m[i] = 1'b1;
    return m;
  endfunction

  initial begin
    logic [N-1:0] v;
    // R6: empty park
    apply('0, "R6");
    // R1 R8: density sweep filling upward, passing every decimal carry
    for (int k = 0; k <= N; k++) apply(low_ones(k), (k % 10 == 0) ? "R8" : "R1");
    // R2: same densities filled from the top bit downward
    for (int k = 0; k <= N; k++) apply(low_ones(k) << (N - k), "R2");
    // R4: all taken
    apply('1, "R4");
    // R5: exactly one space free, at every position
    for (int i = 0; i < N; i++) begin
      v = '1;
      v[i] = 1'b0;
      apply(v, "R5");
    end
    // R7: one full group of four at a time
    for (int g = 0; g < N / 4; g++) apply(N'(4'hF) << (4 * g), "R7");
    // R2 R3: scattered random placements
    for (int r = 0; r < 400; r++) begin
      v = {$urandom, $urandom};
      apply(v, (r % 2 == 0) ? "R2" : "R3");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule